// File: doc/BRIEF.md
# Dual-Channel Prescaled Pulse-Width Modulator

This block is a memory-mapped pulse-width modulator with two independent output pins. A shared control word selects, for each channel, a clock divider, the run controls and the level that counts as active. A separate period/duty word per channel sets how many divided ticks one period lasts and for how many of them the pin is active. Each channel's divider is picked from a fixed, uneven set of ratios between 120 and 72000. Some codes are reserved. When the extended feature set is built in, the divider can also be skipped entirely.

New period/duty values go into a staging copy first. A running channel moves that copy into its working counters only at the end of the current period, so software never produces a torn period. While a staged value is still waiting, the channel's ready flag is high, and with the extended feature set a further period/duty write to that channel is dropped. Each channel is built around a three-state machine: `PH_OFF` (stopped), `PH_ACTIVE` (driving the active phase) and `PH_IDLE` (driving the inactive phase). These are the transitions:
- OFF→ACTIVE or OFF→IDLE happens one clock after the channel is started, depending on whether the duty is non-zero.
- ACTIVE↔IDLE follows the comparison of position against duty.
- Any running state goes to OFF when the run condition drops.

Top module: `dual_pwm`

## Requirements
- R1: Register map, selected by byte address bits [3:2]:
  - Address 0x0 is the control word. Channel n's fields sit at bit offset 15·n: divider code in [3:0], enable at 4, active level at 5, clock gate at 6, divider skip at 9. Ready flag n reads at bit 28+n.
  - Addresses 0x4 and 0x8 hold channel 0 and channel 1 as {period−1 [31:16], duty [15:0]}.
  - All other control bits read 0, and other addresses read 0.
- R2: A channel runs only while both its enable and clock-gate bits are 1. Otherwise its pin sits at the inactive level from the clock after the bits change, and its position and divider count return to zero. After a start, the first period begins one clock after the control write.
- R3: A period lasts period−1+1 ticks, and the pin is active at positions 0 to duty−1. A duty of at least the period length keeps the pin active throughout, and a duty of 0 keeps it inactive.
- R4: With the active-level bit at 1 the pin is active-high; with it at 0 the pin is active-low.
- R5: Divider codes 0–4 give one tick per 120, 180, 240, 360 and 480 clocks. Codes 8–12 give one tick per 12000, 24000, 36000, 48000 and 72000 clocks. Reserved codes (5–7, 13, 14) produce no ticks, so the pin holds its level.
- R6: With the extended feature set, code 0xF or the divider-skip bit gives one tick per clock.
- R7: A period/duty write sets that channel's ready flag. The flag clears when the staged value is taken into the working counters, which happens at the end of a running period or on the next clock if the channel is stopped.
- R8: With the extended feature set, a period/duty write to a channel whose ready flag is 1 is dropped, and the staged value is unchanged.
- R9: A running channel keeps its old period and duty until the current period ends. The new values apply from position 0 of the next period.
- R10: After reset, every register reads 0 and both pins are at 1, the inactive level for active-level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the divider input |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one word per asserted clock |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | 2 | PWM output pins, bit n for channel n |

## Verification
A register write lands on the clock edge it is presented at, so its readback and any change of active level on the pin are due in the same low phase that follows. A start or stop reaches the pin one edge later. A staged period is taken at the edge where the position wraps, and a stopped channel clears its ready flag one edge after the write. The bench drives every input on the falling edge. It reads data 2 ns later, before the next rising edge, and compares both pins with a behavioural model at every falling edge, so each result is sampled in the exact cycle it is due. The duty-ratio and hold checks count pin levels over whole periods rather than single cycles.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

    // Control-word layout, fixed because software decodes it
    localparam int CH_STRIDE = 15;
    localparam int OFS_CODE  = 0;
    localparam int OFS_EN    = 4;
    localparam int OFS_ACT   = 5;
    localparam int OFS_GATE  = 6;
    localparam int OFS_SKIP  = 9;
    localparam int RDY_BASE  = 28;

    // Divider count width covers the largest ratio (72000)
    localparam int PRE_W = 17;

    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_ACTIVE = 2'd1,
        PH_IDLE   = 2'd2
    } phase_e;

    typedef struct packed {
        logic [3:0] code;
        logic       en;
        logic       act;
        logic       gate;
        logic       skip;
    } ch_ctrl_t;

    // Returns {valid, terminal count}; reserved codes give valid = 0
    function automatic logic [PRE_W:0] div_limit(input logic [3:0] code);
        logic [PRE_W:0] r;
        case (code)
            4'd0:    r = {1'b1, 17'd119};
            4'd1:    r = {1'b1, 17'd179};
            4'd2:    r = {1'b1, 17'd239};
            4'd3:    r = {1'b1, 17'd359};
            4'd4:    r = {1'b1, 17'd479};
            4'd8:    r = {1'b1, 17'd11999};
            4'd9:    r = {1'b1, 17'd23999};
            4'd10:   r = {1'b1, 17'd35999};
            4'd11:   r = {1'b1, 17'd47999};
            4'd12:   r = {1'b1, 17'd71999};
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm2_regs.sv
module pwm2_regs
    import pwm2_pkg::*;
#(
    parameter int NCH     = 2,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int ADDR_W  = 4,
    parameter bit HAS_EXT = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    input  logic [NCH-1:0]              ch_busy,
    output logic [DATA_W-1:0]           bus_rdata,
    output ch_ctrl_t [NCH-1:0]          ctrl_q,
    output logic [NCH-1:0][CNT_W-1:0]   sh_prd,
    output logic [NCH-1:0][CNT_W-1:0]   sh_dty,
    output logic [NCH-1:0]              wr_acc
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              unused_bits;

    assign word        = bus_addr[ADDR_W-1:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    // Shared control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_we && word == '0) begin
            for (int n = 0; n < NCH; n++) begin
                ctrl_q[n].code <= bus_wdata[n*CH_STRIDE + OFS_CODE +: 4];
                ctrl_q[n].en   <= bus_wdata[n*CH_STRIDE + OFS_EN];
                ctrl_q[n].act  <= bus_wdata[n*CH_STRIDE + OFS_ACT];
                ctrl_q[n].gate <= bus_wdata[n*CH_STRIDE + OFS_GATE];
                ctrl_q[n].skip <= HAS_EXT ? bus_wdata[n*CH_STRIDE + OFS_SKIP] : 1'b0;
            end
        end
    end

    // Per-channel staging copies of period/duty
    for (genvar g = 0; g < NCH; g++) begin : g_stage
        assign wr_acc[g] = bus_we && (word == WORD_W'(g + 1)) && !(HAS_EXT && ch_busy[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_prd[g] <= '0;
                sh_dty[g] <= '0;
            end else if (wr_acc[g]) begin
                sh_prd[g] <= bus_wdata[DATA_W-1 -: CNT_W];
                sh_dty[g] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (word == '0) begin
            for (int n = 0; n < NCH; n++) begin
                bus_rdata[n*CH_STRIDE + OFS_CODE +: 4] = ctrl_q[n].code;
                bus_rdata[n*CH_STRIDE + OFS_EN]        = ctrl_q[n].en;
                bus_rdata[n*CH_STRIDE + OFS_ACT]       = ctrl_q[n].act;
                bus_rdata[n*CH_STRIDE + OFS_GATE]      = ctrl_q[n].gate;
                bus_rdata[n*CH_STRIDE + OFS_SKIP]      = ctrl_q[n].skip;
                if (HAS_EXT) begin
                    bus_rdata[RDY_BASE + n] = ch_busy[n];
                end
            end
        end else begin
            for (int n = 0; n < NCH; n++) begin
                if (word == WORD_W'(n + 1)) begin
                    bus_rdata = {sh_prd[n], sh_dty[n]};
                end
            end
        end
    end

endmodule

// File: rtl/pwm2_prescale.sv
module pwm2_prescale
    import pwm2_pkg::*;
#(
    parameter bit HAS_EXT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [3:0] code,
    input  logic       skip,
    output logic       tick
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] lim;
    logic             vld;

    if (HAS_EXT) begin : g_skip
        always_comb begin
            {vld, lim} = div_limit(code);
            if (code == 4'hF || skip) begin
                vld = 1'b1;
                lim = '0;
            end
        end
    end else begin : g_noskip
        logic unused_skip;
        assign unused_skip = skip;
        assign {vld, lim}  = div_limit(code);
    end

    assign tick = !clr && vld && (cnt_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !vld || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel
    import pwm2_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             act_lvl,
    input  logic             tick,
    input  logic             wr_acc,
    input  logic [CNT_W-1:0] sh_prd,
    input  logic [CNT_W-1:0] sh_dty,
    output logic             busy,
    output logic             clr,
    output logic             pwm
);

    phase_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] prd_q, prd_d;
    logic [CNT_W-1:0] dty_q, dty_d;
    logic             busy_q;
    logic             period_end;
    logic             latch;

    assign period_end = (cnt_q >= prd_q);
    assign latch      = busy_q && (!run || (tick && period_end));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_OFF;
            cnt_q   <= '0;
            prd_q   <= '0;
            dty_q   <= '0;
            busy_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            prd_q   <= prd_d;
            dty_q   <= dty_d;
            if (wr_acc) begin
                busy_q <= 1'b1;
            end else if (latch) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Next state and counters
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        prd_d   = latch ? sh_prd : prd_q;
        dty_d   = latch ? sh_dty : dty_q;
        unique case (state_q)
            PH_OFF: begin
                cnt_d = '0;
                if (run) begin
                    state_d = (dty_q != '0) ? PH_ACTIVE : PH_IDLE;
                end
            end
            PH_ACTIVE, PH_IDLE: begin
                if (!run) begin
                    state_d = PH_OFF;
                    cnt_d   = '0;
                end else begin
                    if (tick) begin
                        cnt_d = period_end ? '0 : cnt_q + 1'b1;
                    end
                    state_d = (cnt_d < dty_d) ? PH_ACTIVE : PH_IDLE;
                end
            end
            default: begin
                state_d = PH_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        pwm  = (state_q == PH_ACTIVE) ? act_lvl : ~act_lvl;
        clr  = (state_q == PH_OFF) || !run;
        busy = busy_q;
    end

endmodule

// File: rtl/dual_pwm.sv
module dual_pwm
    import pwm2_pkg::*;
#(
    parameter int NCH     = 2,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int ADDR_W  = 4,
    parameter bit HAS_EXT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_o
);

    ch_ctrl_t [NCH-1:0]        ctrl_q;
    logic [NCH-1:0][CNT_W-1:0] sh_prd;
    logic [NCH-1:0][CNT_W-1:0] sh_dty;
    logic [NCH-1:0]            wr_acc;
    logic [NCH-1:0]            ch_busy;
    logic [NCH-1:0]            ch_tick;
    logic [NCH-1:0]            ch_clr;

    pwm2_regs #(
        .NCH(NCH), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .ADDR_W(ADDR_W), .HAS_EXT(HAS_EXT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ch_busy(ch_busy), .bus_rdata(bus_rdata),
        .ctrl_q(ctrl_q), .sh_prd(sh_prd), .sh_dty(sh_dty), .wr_acc(wr_acc)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic run;
        assign run = ctrl_q[g].en && ctrl_q[g].gate;

        pwm2_prescale #(.HAS_EXT(HAS_EXT)) u_pre (
            .clk(clk), .rst_n(rst_n), .clr(ch_clr[g]),
            .code(ctrl_q[g].code), .skip(ctrl_q[g].skip), .tick(ch_tick[g])
        );

        pwm2_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .run(run), .act_lvl(ctrl_q[g].act),
            .tick(ch_tick[g]), .wr_acc(wr_acc[g]), .sh_prd(sh_prd[g]),
            .sh_dty(sh_dty[g]), .busy(ch_busy[g]), .clr(ch_clr[g]),
            .pwm(pwm_o[g])
        );
    end

endmodule

// File: rtl/dual_pwm_chk.sv
module dual_pwm_chk
    import pwm2_pkg::*;
#(
    parameter int NCH     = 2,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int ADDR_W  = 4,
    parameter bit HAS_EXT = 1'b1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_we,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DATA_W-1:0]         bus_rdata,
    input ch_ctrl_t [NCH-1:0]        ctrl_q,
    input logic [NCH-1:0]            ch_busy,
    input logic [NCH-1:0][CNT_W-1:0] sh_prd,
    input logic [NCH-1:0][CNT_W-1:0] sh_dty,
    input logic [NCH-1:0]            pwm_o
);

    localparam int WORD_W = ADDR_W - 2;

    function automatic logic [DATA_W-1:0] ctrl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int n = 0; n < NCH; n++) begin
            m[n*CH_STRIDE +: 7] = 7'h7F;
            m[n*CH_STRIDE + OFS_SKIP] = HAS_EXT;
            m[RDY_BASE + n] = HAS_EXT;
        end
        return m;
    endfunction

    logic [WORD_W-1:0] word;
    assign word = bus_addr[ADDR_W-1:2];

    // R1: reserved control bits read as zero
    always_comb begin
        if (rst_n && word == '0) begin
            a_r1_reserved_zero: assert ((bus_rdata & ~ctrl_mask()) == '0)
                else $error("reserved control bits set");
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_a
        a_r2_stopped_inactive: assert property (@(posedge clk) disable iff (!rst_n)
            !(ctrl_q[g].en && ctrl_q[g].gate) |=> (pwm_o[g] == ~ctrl_q[g].act));

        a_r7_ready_on_write: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && word == WORD_W'(g + 1) && !ch_busy[g]) |=> ch_busy[g]);

        if (HAS_EXT) begin : g_ext
            a_r8_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && word == WORD_W'(g + 1) && ch_busy[g])
                    |=> ($stable(sh_prd[g]) && $stable(sh_dty[g])));
        end
    end

endmodule

bind dual_pwm dual_pwm_chk #(
    .NCH(NCH), .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .HAS_EXT(HAS_EXT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .ctrl_q(ctrl_q), .ch_busy(ch_busy),
    .sh_prd(sh_prd), .sh_dty(sh_dty), .pwm_o(pwm_o)
);

// File: tb/dual_pwm_tb_top.sv
`timescale 1ns/1ps
module dual_pwm_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_pwm dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
    );

    // ---------------- behavioural reference model ----------------
    int m_state[2];   // 0 stopped, 1 active phase, 2 inactive phase
    int m_pos[2];
    int m_sub[2];
    int m_prd[2];
    int m_dty[2];
    int m_sprd[2];
    int m_sdty[2];
    bit m_busy[2];
    logic [31:0] m_ctrl;

    function automatic int ratio(input int code, input bit skip);
        if (skip) return 1;
        case (code)
            0: return 120;   1: return 180;   2: return 240;
            3: return 360;   4: return 480;   8: return 12000;
            9: return 24000; 10: return 36000; 11: return 48000;
            12: return 72000; 15: return 1;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit old_busy[2];
        if (!rst_n) begin
            m_ctrl = '0;
            for (int c = 0; c < 2; c++) begin
                m_state[c] = 0; m_pos[c] = 0; m_sub[c] = 0;
                m_prd[c] = 0; m_dty[c] = 0; m_sprd[c] = 0; m_sdty[c] = 0;
                m_busy[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                int b;
                int d;
                bit run;
                bit tk;
                old_busy[c] = m_busy[c];
                b = c * 15;
                run = m_ctrl[b+4] && m_ctrl[b+6];
                if (!run) begin
                    m_state[c] = 0; m_pos[c] = 0; m_sub[c] = 0;
                    if (m_busy[c]) begin
                        m_prd[c] = m_sprd[c]; m_dty[c] = m_sdty[c]; m_busy[c] = 0;
                    end
                end else if (m_state[c] == 0) begin
                    m_state[c] = (m_dty[c] > 0) ? 1 : 2;
                    m_sub[c] = 0;
                end else begin
                    d = ratio(int'(m_ctrl[b +: 4]), m_ctrl[b+9]);
                    tk = 0;
                    if (d == 0) m_sub[c] = 0;
                    else if (m_sub[c] >= d - 1) begin tk = 1; m_sub[c] = 0; end
                    else m_sub[c]++;
                    if (tk) begin
                        if (m_pos[c] >= m_prd[c]) begin
                            m_pos[c] = 0;
                            if (m_busy[c]) begin
                                m_prd[c] = m_sprd[c]; m_dty[c] = m_sdty[c]; m_busy[c] = 0;
                            end
                        end else m_pos[c]++;
                    end
                    m_state[c] = (m_pos[c] < m_dty[c]) ? 1 : 2;
                end
            end
            if (bus_we) begin
                if (bus_addr[3:2] == 2'd0) m_ctrl = bus_wdata & 32'h013F827F;
                for (int c = 0; c < 2; c++) begin
                    if (bus_addr[3:2] == 2'(c + 1) && !old_busy[c]) begin
                        m_sprd[c] = int'(bus_wdata[31:16]);
                        m_sdty[c] = int'(bus_wdata[15:0]);
                        m_busy[c] = 1;
                    end
                end
            end
        end
    end

    // R3 R4 R9: pins compared with the model every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < 2; c++) begin
                logic act;
                logic exp;
                act = m_ctrl[c*15 + 5];
                exp = (m_state[c] == 1) ? act : ~act;
                checks++;
                if (pwm_o[c] !== exp) begin
                    errors++;
                    $display("FAIL R3 R4 R9 ch%0d pin at %0t: actual %b expected %b",
                             c, $time, pwm_o[c], exp);
                end
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_now(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #2;
        check(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_now(a, exp, tag);
    endtask

    task automatic wait_ready(input int c, input string tag);
        bit clear;
        clear = 0;
        for (int i = 0; i < 24 && !clear; i++) begin
            @(negedge clk);
            bus_addr = 4'h0;
            #2;
            if (bus_rdata[28 + c] == 1'b0) clear = 1;
        end
        check(clear, tag, {31'd0, !clear}, 32'd0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int cnt;
        logic held;
        repeat (4) @(negedge clk);
        #3 rst_n = 1'b1;

        // R10: reset state
        rd_chk(4'h0, 32'h0, "R10 control after reset");
        rd_now(4'h4, 32'h0, "R10 period0 after reset");
        rd_now(4'h8, 32'h0, "R10 period1 after reset");
        check(pwm_o === 2'b11, "R10 pins after reset", {30'd0, pwm_o}, 32'd3);

        // R1: field placement and reserved bits
        wr(4'h0, 32'hFFFF_FFFF);
        rd_now(4'h0, 32'h013F_827F, "R1 control readback mask");
        rd_now(4'hC, 32'h0, "R1 unmapped address");
        wr(4'h0, 32'h0);

        // R7: ready flag on a stopped channel
        wr(4'h4, {16'd9, 16'd3});
        rd_now(4'h0, 32'h1000_0000, "R7 ready set by write");
        rd_chk(4'h0, 32'h0, "R7 ready cleared on stopped channel");
        rd_now(4'h4, 32'h0009_0003, "R1 period0 readback");

        // R2 R6: start channel 0, code 0xF, active-high
        wr(4'h0, 32'h0000_007F);
        check(pwm_o[0] === 1'b0, "R2 pin inactive before start", {31'd0, pwm_o[0]}, 32'd0);
        @(negedge clk);
        check(pwm_o[0] === 1'b1, "R2 first period begins", {31'd0, pwm_o[0]}, 32'd1);
        repeat (25) @(negedge clk);

        // R8 R9: restage while running, second write dropped
        wr(4'h4, {16'd4, 16'd2});
        rd_now(4'h0, 32'h1000_007F, "R7 ready set while running");
        wr(4'h4, {16'd7, 16'd7});
        rd_now(4'h4, 32'h0004_0002, "R8 busy write dropped");
        wait_ready(0, "R7 ready cleared at period end");
        repeat (12) @(negedge clk);

        // R3: duty equal to period and duty zero
        wr(4'h4, {16'd4, 16'd5});
        wait_ready(0, "R7 ready cleared full duty");
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (pwm_o[0] === 1'b1) cnt++;
        end
        check(cnt == 10, "R3 full duty stays active", cnt, 10);
        wr(4'h4, {16'd4, 16'd0});
        wait_ready(0, "R7 ready cleared zero duty");
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (pwm_o[0] === 1'b0) cnt++;
        end
        check(cnt == 10, "R3 zero duty stays inactive", cnt, 10);

        // R4: active level 0 inverts the pin
        wr(4'h0, 32'h0000_005F);
        check(pwm_o[0] === 1'b1, "R4 inverted idle level", {31'd0, pwm_o[0]}, 32'd1);

        // R5: channel 1 with code 0 (divide by 120), period 3 ticks, duty 1
        wr(4'h8, {16'd2, 16'd1});
        wr(4'h0, 32'h0038_005F);
        cnt = 0;
        for (int i = 0; i < 1080; i++) begin
            @(negedge clk);
            if (pwm_o[1] === 1'b1) cnt++;
        end
        check(cnt == 360, "R5 divide-by-120 active cycles", cnt, 360);

        // R5: reserved code freezes the pin
        wr(4'h0, 32'h003A_805F);
        @(negedge clk);
        held = pwm_o[1];
        cnt = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (pwm_o[1] !== held) cnt++;
        end
        check(cnt == 0, "R5 reserved code holds level", cnt, 0);

        // R6: divider-skip bit with code 0
        wr(4'h0, 32'h0138_005F);
        repeat (5) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pwm_o[1] === 1'b1) cnt++;
        end
        check(cnt == 10, "R6 skip bit gives one tick per clock", cnt, 10);

        // R2: stop both channels
        wr(4'h0, 32'h0);
        @(negedge clk);
        check(pwm_o === 2'b11, "R2 stopped pins inactive", {30'd0, pwm_o}, 32'd3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule